// File: doc/BRIEF.md
# Machine-Cycle Event Counter Front-End

This block sits in front of a pair of timer/counter registers and decides, on each oscillator clock, whether they should advance. It divides the oscillator clock into machine cycles of twelve clocks. Each machine cycle walks through six states of two phases each, named S1P1 to S6P2 (indices 0 to 11). Once per machine cycle it gives a timer-mode increment pulse. A register in timer mode advances on that pulse.

For each external count pin, the block first passes the pin through a two-flop synchronizer. It then takes one sample per machine cycle, at the end of phase S5P2. A small per-pin state machine tracks the samples and has three states:
- `LVL_HIGH`: the last sample was high.
- `LVL_FELL`: a high sample was followed by a low sample.
- `LVL_LOW`: a low sample was followed by another low sample.

At each sample point the machine moves to `LVL_HIGH` if the new sample is high. If the new sample is low, it moves from `LVL_HIGH` to `LVL_FELL`, and from `LVL_FELL` or `LVL_LOW` to `LVL_LOW`. While a pin is in `LVL_FELL`, a one-clock counter-mode pulse is issued at S3P1 of the following machine cycle. This makes the fastest countable input one transition per 24 clocks.

The phase sequencer is a twelve-state machine (`PH_S1P1` … `PH_S6P2`). It advances one state per clock and goes from `PH_S6P2` back to `PH_S1P1`.

Top module: `evt_count_frontend`

## Requirements
- R1: `phase_o` is 0 during and right after reset, and it increases by one per clock from 0 to 11, then wraps to 0.
- R2: `tick_o` is high for exactly one clock in each machine cycle, the clock in which `phase_o` equals 4 (S3P1).
- R3: Each pin passes through two synchronizer flops that reset high, so a change on the pin reaches the sampler two clocks later.
- R4: Each pin is sampled only on the clock edge that ends phase 9 (S5P2). A low level that does not cover that sampling point is never counted, and a short low level that does cover it is counted.
- R5: A counter-mode pulse on `evt_o[i]` is produced only when a high sample is followed by a low sample. There is one pulse per such pair, and a pin held low gives no further pulses.
- R6: The pulse for a low sample taken in machine cycle k appears in machine cycle k+1, at the clock where `phase_o` is 4. It is one clock wide.
- R7: Reset leaves each pin's tracker in `LVL_HIGH`, so a pin held high after reset produces no pulse.
- R8: The pins are tracked independently. Bit i of `pin_i` only drives bit i of `evt_o`.
- R9: A pin that alternates low and high on successive machine cycles is counted once every 24 clocks, which is the maximum rate. Two pulses on one pin are never closer than 24 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | External count pins, asynchronous |
| phase_o | output | 4 | State/phase index within the machine cycle (0 = S1P1 … 11 = S6P2) |
| tick_o | output | 1 | Timer-mode increment pulse, once per machine cycle |
| evt_o | output | NUM_PINS | Counter-mode increment pulses, one per detected falling edge |

## Verification
`tick_o` is due in the clock where the phase index is 4, and the phase index is due one clock after the previous value. For a pin that changes at phase 0 of cycle k, the synchronizer adds two clocks and the sample is taken at the end of phase 9. The pulse is therefore due exactly 16 clocks after the change, at phase 4 of cycle k+1. The bench drives pins on falling clock edges, at phase 0 or at chosen phases inside a cycle. It keeps its own phase count, which starts at reset release, and checks every output on falling edges at the phase where each result is due and also at all other phases. The table vectors hold each level for whole machine cycles and compare the pulse totals with the number of high-to-low transitions worked out by hand. The directed cases check the exact 16-clock latency and glitches that either cover or miss the sampling point.

// File: rtl/efe_pkg.sv
package efe_pkg;
    localparam int MC_LEN = 12;
    localparam int PH_W   = $clog2(MC_LEN);

    typedef enum logic [PH_W-1:0] {
        PH_S1P1, PH_S1P2, PH_S2P1, PH_S2P2, PH_S3P1, PH_S3P2,
        PH_S4P1, PH_S4P2, PH_S5P1, PH_S5P2, PH_S6P1, PH_S6P2
    } mc_phase_e;

    typedef enum logic [1:0] {
        LVL_HIGH,
        LVL_FELL,
        LVL_LOW
    } samp_state_e;
endpackage

// File: rtl/efe_phase_seq.sv
module efe_phase_seq
    import efe_pkg::*;
#(
    parameter int SMP_PH = 9,
    parameter int UPD_PH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            sample_stb_o,
    output logic            update_stb_o
);
    mc_phase_e ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_S1P1;
        else        ph_q <= ph_d;
    end

    always_comb begin
        unique case (ph_q)
            PH_S6P2: ph_d = PH_S1P1;
            default: ph_d = mc_phase_e'(ph_q + 1'b1);
        endcase
    end

    always_comb begin
        phase_o      = ph_q;
        sample_stb_o = (ph_q == mc_phase_e'(SMP_PH));
        update_stb_o = (ph_q == mc_phase_e'(UPD_PH));
    end
endmodule

// File: rtl/efe_pin_sampler.sv
module efe_pin_sampler
    import efe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sample_stb_i,
    input  logic update_stb_i,
    output logic evt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    samp_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LVL_HIGH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (sample_stb_i) begin
            if (sync_q[SYNC_STAGES-1]) begin
                st_d = LVL_HIGH;
            end else begin
                unique case (st_q)
                    LVL_HIGH: st_d = LVL_FELL;
                    LVL_FELL: st_d = LVL_LOW;
                    LVL_LOW:  st_d = LVL_LOW;
                    default:  st_d = LVL_HIGH;
                endcase
            end
        end
    end

    always_comb begin
        evt_o = (st_q == LVL_FELL) && update_stb_i;
    end
endmodule

// File: rtl/evt_count_frontend.sv
module evt_count_frontend
    import efe_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SMP_PH      = 9,
    parameter int UPD_PH      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [PH_W-1:0]     phase_o,
    output logic                tick_o,
    output logic [NUM_PINS-1:0] evt_o
);
    logic sample_stb;
    logic update_stb;

    efe_phase_seq #(
        .SMP_PH(SMP_PH),
        .UPD_PH(UPD_PH)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_o     (phase_o),
        .sample_stb_o(sample_stb),
        .update_stb_o(update_stb)
    );

    assign tick_o = update_stb;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        efe_pin_sampler #(
            .SYNC_STAGES(SYNC_STAGES)
        ) i_smp (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_i       (pin_i[g]),
            .sample_stb_i(sample_stb),
            .update_stb_i(update_stb),
            .evt_o       (evt_o[g])
        );
    end
endmodule

// File: rtl/evt_count_frontend_chk.sv
module evt_count_frontend_chk
    import efe_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int UPD_PH   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PH_W-1:0]     phase_o,
    input logic                tick_o,
    input logic [NUM_PINS-1:0] evt_o
);
    localparam int MIN_GAP = 2 * MC_LEN;
    localparam int GAP_W   = $clog2(MIN_GAP) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_W'(MC_LEN - 1)) |=> (phase_o == '0));

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != PH_W'(MC_LEN - 1)) |=> (phase_o == $past(phase_o) + 1'b1));

    // R2
    tick_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (phase_o == PH_W'(UPD_PH)));

    // R2
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R6
    evt_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != '0) |-> tick_o);

    // R6
    evt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != '0) |=> (evt_o == '0));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_gap
        logic [GAP_W-1:0] gap_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             gap_q <= GAP_MAX;
            else if (evt_o[g])      gap_q <= '0;
            else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
        end
        // R9
        evt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[g] |-> (gap_q >= GAP_W'(MIN_GAP - 1)));
    end
endmodule

bind evt_count_frontend evt_count_frontend_chk #(
    .NUM_PINS(NUM_PINS),
    .UPD_PH  (UPD_PH)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_o(phase_o),
    .tick_o (tick_o),
    .evt_o  (evt_o)
);

// File: tb/test_evt_count_frontend.sv
module test_evt_count_frontend;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '1;
    logic [3:0]    phase;
    logic          tick;
    logic [NP-1:0] evt;

    int n_chk = 0;
    int n_bad = 0;
    int bp = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_count_frontend #(.NUM_PINS(NP)) i_evt_count_frontend (
        .clk(clk), .rst_n(rst_n), .pin_i(pin),
        .phase_o(phase), .tick_o(tick), .evt_o(evt)
    );

    typedef struct packed {
        logic [15:0] l0;
        logic [15:0] l1;
        logic [7:0]  e0;
        logic [7:0]  e1;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'hFFFF, 16'hFFFF, 8'd0, 8'd0},
        '{16'hD555, 16'hFFFF, 8'd7, 8'd0},
        '{16'hFF0F, 16'h8001, 8'd1, 8'd1},
        '{16'hF0F1, 16'hDB6D, 8'd2, 8'd5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        bp = (bp == 11) ? 0 : bp + 1;
    endtask

    task automatic align0();
        while (bp != 0) step();
    endtask

    // Per-negedge checks of phase and tick, plus pulse counting.
    task automatic look(inout int c0, inout int c1);
        check(phase == 4'(bp), "R1 phase", phase, bp);
        check(tick == (bp == 4), "R2 tick", tick, bp == 4);
        if (evt != 0) check(bp == 4, "R6 evt phase", bp, 4);
        c0 += evt[0];
        c1 += evt[1];
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, c1;
        // Reset state (R1, R2, R7)
        repeat (3) @(negedge clk);
        check(phase == 0, "R1 reset phase", phase, 0);
        check(tick == 0, "R2 reset tick", tick, 0);
        check(evt == 0, "R7 reset evt", evt, 0);
        rst_n = 1'b1;
        bp = 0;

        // R7: pins high after reset, two cycles, no pulses
        c0 = 0; c1 = 0;
        repeat (24) begin look(c0, c1); step(); end
        check(c0 + c1 == 0, "R7 idle no pulse", c0 + c1, 0);

        // Table vectors (R5, R8, R9)
        for (int v = 0; v < 4; v++) begin
            int ticks;
            align0();
            c0 = 0; c1 = 0; ticks = 0;
            for (int c = 0; c < 16; c++) begin
                for (int p = 0; p < 12; p++) begin
                    if (p == 0) pin = {VECS[v].l1[c], VECS[v].l0[c]};
                    look(c0, c1);
                    ticks += tick;
                    step();
                end
            end
            check(c0 == VECS[v].e0, "R5 R9 pin0 count", c0, VECS[v].e0);
            check(c1 == VECS[v].e1, "R5 R8 pin1 count", c1, VECS[v].e1);
            check(ticks == 16, "R2 ticks per vector", ticks, 16);
        end

        // R3 R6: exact latency, pin0 falls at phase 0 of cycle k
        align0();
        pin[0] = 1'b0;
        for (int i = 0; i < 36; i++) begin
            check(evt[0] == (i == 16), "R6 R3 latency", evt[0], i == 16);
            check(evt[1] == 1'b0, "R8 other pin quiet", evt[1], 0);
            step();
        end
        // R5: held low gives nothing more
        c0 = 0; c1 = 0;
        repeat (24) begin look(c0, c1); step(); end
        check(c0 == 0, "R5 held low", c0, 0);
        align0();
        pin[0] = 1'b1;
        repeat (24) begin look(c0, c1); step(); end
        check(c0 == 0, "R5 rise no pulse", c0, 0);

        // R4: pin0 glitch misses sample point, pin1 glitch covers it
        align0();
        c0 = 0; c1 = 0;
        for (int i = 0; i < 36; i++) begin
            if (i == 0)  pin[0] = 1'b0;
            if (i == 5)  pin[0] = 1'b1;
            if (i == 6)  pin[1] = 1'b0;
            if (i == 11) pin[1] = 1'b1;
            if (i == 16) check(evt[1] == 1'b1, "R4 short low counted", evt[1], 1);
            look(c0, c1);
            step();
        end
        check(c0 == 0, "R4 glitch missed", c0, 0);
        check(c1 == 1, "R4 glitch counted", c1, 1);

        // R9: alternating every cycle, one pulse per 24 clocks
        align0();
        c0 = 0; c1 = 0;
        for (int c = 0; c < 12; c++) begin
            for (int p = 0; p < 12; p++) begin
                if (p == 0) pin[0] = c[0];
                look(c0, c1);
                step();
            end
        end
        pin[0] = 1'b1;
        repeat (24) begin look(c0, c1); step(); end
        check(c0 == 6, "R9 max rate", c0, 6);

        // R1 R7: reset mid-run
        repeat (5) step();
        rst_n = 1'b0;
        @(negedge clk);
        check(phase == 0, "R1 mid reset phase", phase, 0);
        check(evt == 0 && tick == 0, "R7 mid reset outputs", {evt, tick}, 0);
        rst_n = 1'b1;
        bp = 0;
        c0 = 0; c1 = 0;
        repeat (24) begin look(c0, c1); step(); end
        check(c0 + c1 == 0, "R7 after reset quiet", c0 + c1, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule